// File: doc/BRIEF.md
# Segmented Row-Column Current-Cell Decoder

This block turns a 14-bit amplitude word into the enable pattern for a segmented current-cell array. The ten most significant bits select how many of 1024 equal-weight cells are switched on. These cells sit in a 32 by 32 grid, and two 5-bit thermometer codes address them: one code drives the row lines and one drives the column lines. A small combinational decoder at each cell looks at the lines that pass it. The four least significant bits go straight to four binary-weighted cells. The cells are ordered so that unary code N turns on exactly the N lowest-indexed cells, where index = row × 32 + column.

Each cell that is about to switch on first receives a pre-charge enable. The pre-charge decode uses a second, inverted copy of the row and column lines. That copy is launched on the falling clock edge, half a period before the true lines update on the rising edge. A pulse is raised only for cells that go from off to on, and it lasts only for that half period. Cells that were already on get no pulse, and neither do cells that are switching off.

A rising edge captures the input word. The next rising edge moves the row, column and binary lines to the output. The inverted early lines move on the falling edge between those two rising edges.

Top module: `segdac_cell_decoder`

## Requirements
- R1: While reset is held, and until a new word has been captured, all cell enables, pre-charge enables, row lines, column lines and binary enables are 0, and the inverted early lines are all 1.
- R2: After the second rising edge from the one that captures word C, unary cell index i (i = row × 32 + column) is on exactly when i < C[13:4].
- R3: Row line r is high exactly when r < C[13:9]. Column line c is high exactly when c < C[8:4]. Both update on the same rising edge as the cells.
- R4: Binary enable bit k, of weight 2^k, equals C[k] for k = 0..3, with the same latency as the unary cells.
- R5: In the half period between the falling edge and the rising edge that turns the new pattern on, the pre-charge enable is high exactly for cells (unary and binary) that are off in the old pattern and on in the new one. In the other half period it is 0.
- R6: The inverted early row and column lines take the complement of the new row and column codes on the falling edge that follows capture, half a period before the true lines.
- R7: For every one of the 16384 input words, 16 × (number of active unary cells) + the binary enable value equals the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_i | input | 14 | Amplitude word |
| row_therm_o | output | 32 | Row thermometer lines |
| col_therm_o | output | 32 | Column thermometer lines |
| row_early_n_o | output | 32 | Inverted row lines, launched half a period early |
| col_early_n_o | output | 32 | Inverted column lines, launched half a period early |
| cell_on_o | output | 1024 | Unary cell enables, index row × 32 + column |
| cell_pre_o | output | 1024 | Unary cell pre-charge enables |
| bin_on_o | output | 4 | Binary-weighted cell enables |
| bin_pre_o | output | 4 | Binary cell pre-charge enables |

## Verification
The pre-charge pulse is the hardest behaviour to reach and observe. It exists only in the second half of one clock period, and its exact cell set depends on the old word as well as the new one. Transitions that cross a row boundary are the interesting ones: the partially filled row changes, and a whole row goes thermometer-on. The stimulus walks every word in ascending order, so every single-step change is covered, including every row rollover. It then adds seeded random jumps and directed extremes such as full scale to zero and zero to full scale. After each word, the outputs are sampled once inside the pre-charge half period and once after the rising edge that turns the new cells on.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  localparam int DEF_ROW_BITS = 5;
  localparam int DEF_COL_BITS = 5;
  localparam int DEF_BIN_BITS = 4;
endpackage

// File: rtl/segdac_rst_sync.sv
module segdac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/segdac_therm_enc.sv
module segdac_therm_enc #(
  parameter  int BITS  = 5,
  localparam int LINES = 1 << BITS
) (
  input  logic [BITS-1:0]  bin_i,
  output logic [LINES-1:0] therm_o
);
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      therm_o[i] = ((BITS+1)'(i) < {1'b0, bin_i});
    end
  end

  always_comb begin
    AST_THERM_WEIGHT: assert ($countones(therm_o) == int'(bin_i)); // R3
  end
endmodule

// File: rtl/segdac_cell_array.sv
module segdac_cell_array #(
  parameter  int ROWS  = 32,
  parameter  int COLS  = 32,
  localparam int CELLS = ROWS * COLS
) (
  input  logic [ROWS-1:0]  row_i,
  input  logic [COLS-1:0]  col_i,
  output logic [CELLS-1:0] cell_o
);
  logic [ROWS-1:0] row_part;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == 0) begin : g_first
      assign row_part[r] = ~row_i[r];
    end else begin : g_rest
      assign row_part[r] = row_i[r-1] & ~row_i[r];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign cell_o[r*COLS+c] = row_i[r] | (row_part[r] & col_i[c]);
    end
  end
endmodule

// File: rtl/segdac_cell_decoder.sv
module segdac_cell_decoder #(
  parameter  int ROW_BITS = segdac_pkg::DEF_ROW_BITS,
  parameter  int COL_BITS = segdac_pkg::DEF_COL_BITS,
  parameter  int BIN_BITS = segdac_pkg::DEF_BIN_BITS,
  localparam int ROWS     = 1 << ROW_BITS,
  localparam int COLS     = 1 << COL_BITS,
  localparam int CELLS    = ROWS * COLS,
  localparam int UNA_BITS = ROW_BITS + COL_BITS,
  localparam int CODE_W   = UNA_BITS + BIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic [ROWS-1:0]   row_therm_o,
  output logic [COLS-1:0]   col_therm_o,
  output logic [ROWS-1:0]   row_early_n_o,
  output logic [COLS-1:0]   col_early_n_o,
  output logic [CELLS-1:0]  cell_on_o,
  output logic [CELLS-1:0]  cell_pre_o,
  output logic [BIN_BITS-1:0] bin_on_o,
  output logic [BIN_BITS-1:0] bin_pre_o
);
  logic rst_sync_n;

  segdac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // input capture
  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) code_q <= '0;
    else             code_q <= code_d;
  end

  // thermometer encoders
  logic [ROWS-1:0] row_t;
  logic [COLS-1:0] col_t;

  segdac_therm_enc #(.BITS(ROW_BITS)) u_row_enc (
    .bin_i   (code_q[CODE_W-1 -: ROW_BITS]),
    .therm_o (row_t)
  );

  segdac_therm_enc #(.BITS(COL_BITS)) u_col_enc (
    .bin_i   (code_q[BIN_BITS +: COL_BITS]),
    .therm_o (col_t)
  );

  // early inverted path, falling edge
  logic [ROWS-1:0]     row_early_n_q, row_early_n_d;
  logic [COLS-1:0]     col_early_n_q, col_early_n_d;
  logic [BIN_BITS-1:0] bin_early_q,   bin_early_d;

  always_comb begin
    row_early_n_d = ~row_t;
    col_early_n_d = ~col_t;
    bin_early_d   = code_q[BIN_BITS-1:0];
  end

  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      row_early_n_q <= '1;
      col_early_n_q <= '1;
      bin_early_q   <= '0;
    end else begin
      row_early_n_q <= row_early_n_d;
      col_early_n_q <= col_early_n_d;
      bin_early_q   <= bin_early_d;
    end
  end

  // true lines, rising edge
  logic [ROWS-1:0]     row_line_q, row_line_d;
  logic [COLS-1:0]     col_line_q, col_line_d;
  logic [BIN_BITS-1:0] bin_on_q,   bin_on_d;

  always_comb begin
    row_line_d = row_t;
    col_line_d = col_t;
    bin_on_d   = code_q[BIN_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      row_line_q <= '0;
      col_line_q <= '0;
      bin_on_q   <= '0;
    end else begin
      row_line_q <= row_line_d;
      col_line_q <= col_line_d;
      bin_on_q   <= bin_on_d;
    end
  end

  // per-cell local decoders: switch and pre-charge
  logic [CELLS-1:0] cell_on, cell_next;

  segdac_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_on_dec (
    .row_i  (row_line_q),
    .col_i  (col_line_q),
    .cell_o (cell_on)
  );

  segdac_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_pre_dec (
    .row_i  (~row_early_n_q),
    .col_i  (~col_early_n_q),
    .cell_o (cell_next)
  );

  assign row_therm_o   = row_line_q;
  assign col_therm_o   = col_line_q;
  assign row_early_n_o = row_early_n_q;
  assign col_early_n_o = col_early_n_q;
  assign cell_on_o     = cell_on;
  assign cell_pre_o    = cell_next & ~cell_on;
  assign bin_on_o      = bin_on_q;
  assign bin_pre_o     = bin_early_q & ~bin_on_q;

  AST_UNARY_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ($countones(cell_on_o) == int'($past(code_q[CODE_W-1:BIN_BITS])))); // R2
  AST_BIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (bin_on_o == $past(code_q[BIN_BITS-1:0]))); // R4
  AST_PRE_LANDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (($past(cell_pre_o) & ~cell_on_o) == '0)); // R5
  AST_EARLY_LEAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((row_therm_o == ~$past(row_early_n_o)) && (col_therm_o == ~$past(col_early_n_o)))); // R6
endmodule

// File: tb/segdac_cell_decoder_tb.sv
module segdac_cell_decoder_tb_top;
  logic          clk;
  logic          rst_n;
  logic [13:0]   code_i;
  logic [31:0]   row_therm_o, col_therm_o, row_early_n_o, col_early_n_o;
  logic [1023:0] cell_on_o, cell_pre_o;
  logic [3:0]    bin_on_o, bin_pre_o;

  int n_chk;
  int n_fail;
  int cur;
  bit done;

  segdac_cell_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .code_i(code_i),
    .row_therm_o(row_therm_o), .col_therm_o(col_therm_o),
    .row_early_n_o(row_early_n_o), .col_early_n_o(col_early_n_o),
    .cell_on_o(cell_on_o), .cell_pre_o(cell_pre_o),
    .bin_on_o(bin_on_o), .bin_pre_o(bin_pre_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1023:0] mask_of(input int n);
    logic [1023:0] m;
    for (int i = 0; i < 1024; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [31:0] therm_of(input int n);
    logic [31:0] t;
    for (int i = 0; i < 32; i++) t[i] = (i < n);
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int c);
    int prev;
    logic [1023:0] m_new, m_old;
    logic [3:0] b_new, b_old;
    prev  = cur;
    m_new = mask_of(c >> 4);
    m_old = mask_of(prev >> 4);
    b_new = 4'(c);
    b_old = 4'(prev);
    @(negedge clk);
    code_i = 14'(c);
    @(posedge clk);
    @(negedge clk);
    #1;
    // pre-charge half period
    chk(cell_pre_o == (m_new & ~m_old), "R5", "unary pre", cell_pre_o, m_new & ~m_old);
    chk(bin_pre_o == (b_new & ~b_old), "R5", "binary pre", 1024'(bin_pre_o), 1024'(b_new & ~b_old));
    chk(cell_on_o == m_old, "R5", "cells not yet switched", cell_on_o, m_old);
    chk(row_early_n_o == ~therm_of(c >> 9), "R6", "early row", 1024'(row_early_n_o), 1024'(~therm_of(c >> 9)));
    chk(col_early_n_o == ~therm_of((c >> 4) & 31), "R6", "early col", 1024'(col_early_n_o), 1024'(~therm_of((c >> 4) & 31)));
    @(posedge clk);
    #1;
    chk(cell_on_o == m_new, "R2", "unary cells", cell_on_o, m_new);
    chk(row_therm_o == therm_of(c >> 9), "R3", "row lines", 1024'(row_therm_o), 1024'(therm_of(c >> 9)));
    chk(col_therm_o == therm_of((c >> 4) & 31), "R3", "col lines", 1024'(col_therm_o), 1024'(therm_of((c >> 4) & 31)));
    chk(bin_on_o == b_new, "R4", "binary cells", 1024'(bin_on_o), 1024'(b_new));
    chk(cell_pre_o == '0 && bin_pre_o == '0, "R5", "pre idle first half", cell_pre_o, '0);
    chk($countones(cell_on_o) * 16 + int'(bin_on_o) == c, "R7", "total weight",
        1024'($countones(cell_on_o) * 16 + int'(bin_on_o)), 1024'(c));
    cur = c;
  endtask

  initial begin
    done = 1'b0;
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    n_chk  = 0;
    n_fail = 0;
    seed   = 7;
    void'($urandom(seed));
    rst_n  = 1'b0;
    code_i = 14'h3ABC;
    repeat (5) @(posedge clk);
    #1;
    chk(cell_on_o == '0 && cell_pre_o == '0, "R1", "cells in reset", cell_on_o, '0);
    chk(row_therm_o == '0 && col_therm_o == '0 && bin_on_o == '0 && bin_pre_o == '0,
        "R1", "lines in reset", 1024'({row_therm_o, col_therm_o, bin_on_o}), '0);
    chk(row_early_n_o == '1 && col_early_n_o == '1, "R1", "early lines in reset",
        1024'({row_early_n_o, col_early_n_o}), 1024'({32'hFFFFFFFF, 32'hFFFFFFFF}));
    @(negedge clk);
    code_i = '0;
    rst_n  = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(cell_on_o == '0 && bin_on_o == '0, "R1", "after release", cell_on_o, '0);
    cur = 0;
    // directed corners
    apply(16383);
    apply(0);
    apply(16383);
    apply(16383);
    apply(16'h01F0 & 14'h3FFF);
    apply(16'h0200);
    apply(16'h1FF0);
    apply(16'h2000);
    apply(15);
    apply(16);
    apply(0);
    // exhaustive ascending sweep
    for (int c = 0; c < 16384; c++) apply(c);
    // seeded random jumps
    for (int k = 0; k < 2000; k++) apply(int'($urandom() & 16383));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule